// File: doc/BRIEF.md
# Palette and Gamma Lookup Stage

This block sits in a display video pipeline between pixel fetch and the later stages. It holds a 256-entry color table in which every entry carries red, green and blue components of 10 bits each. It runs in one of two lookup modes.

In indexed mode, each 32-bit input word carries packed palette indices. The block unpacks them, lowest bits first, at a selectable depth of 1, 2, 4 or 8 bits. It emits one opaque RGB pixel per index. In gamma mode, each incoming ARGB pixel has its three color components remapped independently through the table, and alpha is kept as it is. A bypass control passes pixels through untouched.

Software loads the table through a write port while the stage is disabled or bypassed. The stage refuses to run a lookup while the downstream scaler is switched on. Both directions use valid/ready handshakes. A table read adds one register of latency.

Top module: `pal_lut_stage`

## Requirements
- R1: The table holds 256 entries. A write puts `tw_data_i[29:20]` into the red lane, `[19:10]` into the green lane and `[9:0]` into the blue lane of entry `tw_addr_i`, at the next clock edge.
- R2: In indexed mode (`mode_i`=0), `depth_i` codes 0/1/2/3 select 1/2/4/8 bits per index. Indices are taken from `in_data_i[31:0]`, the least significant field first. One word yields 32/16/8/4 pixels, and `in_ready_o` is high only while the last index of the word is offered.
- R3: An indexed output pixel is `{10'h3FF, R, G, B}` of the table entry the index addresses, with the index zero-extended to 8 bits.
- R4: In gamma mode (`mode_i`=1), input and output are `{A[39:30], R[29:20], G[19:10], B[9:0]}`. Output R is the red lane of the entry at `R[9:2]`, G is the green lane at `G[9:2]`, B is the blue lane at `B[9:2]`, and A is copied unchanged.
- R5: With `bypass_i` high, each accepted input word appears unchanged on `out_data_o`, in order, whatever the other mode inputs are.
- R6: An accepted input, or an unpacked index, appears with `out_valid_o` high in the next cycle. While `out_ready_i` is low, `out_valid_o` and `out_data_o` hold and no input is consumed.
- R7: When `en_i` is high, `bypass_i` is low and `scaler_on_i` is high, in either lookup mode, `cfg_err_o` is high and both `out_valid_o` and `in_ready_o` are low. `cfg_err_o` is low at all other times.
- R8: With `en_i` low, `out_valid_o`, `in_ready_o` and `cfg_err_o` are all low.
- R9: A table write with `en_i` high and `bypass_i` low has no effect on the table. A write with `en_i` low or with `bypass_i` high is accepted.
- R10: After reset, with `en_i` high and no input offered, `out_valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Stage enable |
| bypass_i | input | 1 | Pass pixels through unchanged |
| mode_i | input | 1 | 0 = indexed palette, 1 = gamma |
| depth_i | input | 2 | Index depth code (1/2/4/8 bits) |
| scaler_on_i | input | 1 | Scaler enabled elsewhere in the pipeline |
| cfg_err_o | output | 1 | Lookup requested together with scaling |
| tw_en_i | input | 1 | Table write strobe |
| tw_addr_i | input | 8 | Table write entry |
| tw_data_i | input | 30 | Table write data, R/G/B lanes |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word consumed |
| in_data_i | input | 40 | Input word (ARGB or packed indices) |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 40 | Output ARGB pixel |

## Verification
The bench unpacks every index depth using word patterns in which neighbouring fields differ. An unpacker that starts from the wrong end, uses the wrong field width, or releases the word early would emit a wrong or extra pixel. Gamma pixels use different values in each component, so a design that feeds all three lanes from one address, or drops alpha, shows a mismatch. Random output back-pressure exposes a design that loses or repeats a pixel under stall. Writes attempted while the stage runs, and lookups requested with the scaler on, catch a table that takes writes it should ignore and a stage that keeps streaming in an illegal configuration.

// File: rtl/pal_lut_pkg.sv
// Shared constants and types for the palette / gamma lookup stage.
// Assumes 10-bit components, 8-bit table addresses and 32-bit index words.
package pal_lut_pkg;
    localparam int CW     = 10;       // component width
    localparam int AW     = 8;        // table address width
    localparam int WORD_W = 32;       // packed index word width
    localparam int NLANE  = 3;        // R, G, B
    localparam int PIX_W  = 4 * CW;   // ARGB pixel width

    typedef enum logic {
        MODE_IDX = 1'b0,
        MODE_GAM = 1'b1
    } pal_mode_e;

    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_IDX = 2'd1,
        SEL_GAM = 2'd2
    } pal_sel_e;
endpackage

// File: rtl/pal_index_unpack.sv
// Packed index unpacker.
// Presents one index at a time from a packed word, least significant field
// first. It advances on `step` and reports `last` for the final field.
// Assumes depth is held stable while a word is in progress; `clr` restarts it.
module pal_index_unpack #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic [1:0]        depth,
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] cand [4];
    logic             lastv [4];

    // One candidate field extractor per supported depth.
    for (genvar d = 0; d < 4; d++) begin : g_depth
        localparam int BITS = 1 << d;
        localparam int PIX  = WORD_W / BITS;
        localparam int SW   = $clog2(PIX);
        localparam logic [SW-1:0] LASTSUB = SW'(PIX - 1);
        logic [SW-1:0]   sub;
        logic [BITS-1:0] field;
        assign sub       = cnt[SW-1:0];
        assign field     = word[sub*BITS +: BITS];
        assign cand[d]   = IDX_W'(field);
        assign lastv[d]  = (sub == LASTSUB);
    end

    // Select the field and end flag for the configured depth.
    always_comb begin
        idx  = cand[depth];
        last = lastv[depth];
    end

    // Field counter: wraps after the last field of a word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pal_lut_lane.sv
// One color lane of the lookup table: a single-write, single-read memory
// with a registered read port (one cycle read latency).
// Assumes contents are loaded before use; the storage itself is not reset.
module pal_lut_lane #(
    parameter int DW = 10,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Table write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered table read.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/pal_out_stage.sv
// Output register stage.
// Holds the valid bit, the path select and the pass-through word that are
// aligned with the table read, and assembles the output pixel.
// Assumes `adv` is low while the downstream holds a valid pixel unaccepted.
module pal_out_stage #(
    parameter int CW    = 10,
    localparam int PIX_W = 4 * CW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      adv,
    input  logic                      in_valid,
    input  pal_lut_pkg::pal_sel_e     sel_d,
    input  logic [PIX_W-1:0]          pass_d,
    input  logic [CW-1:0]             lane_r,
    input  logic [CW-1:0]             lane_g,
    input  logic [CW-1:0]             lane_b,
    output logic                      valid_q,
    output pal_lut_pkg::pal_sel_e     sel_q,
    output logic [PIX_W-1:0]          data_o
);
    import pal_lut_pkg::*;

    logic [PIX_W-1:0] pass_q;

    // Valid bit: flushed when the stage stops, reloaded on every advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            valid_q <= 1'b0;
        end else if (adv) begin
            valid_q <= in_valid;
        end
    end

    // Path select and pass-through word, captured with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SEL_BYP;
            pass_q <= '0;
        end else if (adv && in_valid) begin
            sel_q  <= sel_d;
            pass_q <= pass_d;
        end
    end

    // Assemble the pixel from the lanes or the pass-through word.
    always_comb begin
        if (sel_q == SEL_BYP) begin
            data_o = pass_q;
        end else begin
            data_o = {pass_q[PIX_W-1 -: CW], lane_r, lane_g, lane_b};
        end
    end
endmodule

// File: rtl/pal_lut_stage.sv
// Palette / gamma lookup stage (top).
// Indexed mode unpacks packed indices into opaque RGB pixels through the
// table. Gamma mode remaps each color component through its own lane.
// Bypass forwards words unchanged. The table is writable only while the
// stage is disabled or bypassed. A lookup with the scaler on is refused.
// Assumes mode, depth and bypass change only while no data is in flight.
module pal_lut_stage #(
    parameter int CW     = pal_lut_pkg::CW,
    parameter int AW     = pal_lut_pkg::AW,
    parameter int WORD_W = pal_lut_pkg::WORD_W,
    localparam int NLANE = pal_lut_pkg::NLANE,
    localparam int PIX_W = 4 * CW,
    localparam int TW_W  = NLANE * CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             bypass_i,
    input  logic             mode_i,
    input  logic [1:0]       depth_i,
    input  logic             scaler_on_i,
    output logic             cfg_err_o,
    input  logic             tw_en_i,
    input  logic [AW-1:0]    tw_addr_i,
    input  logic [TW_W-1:0]  tw_data_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [PIX_W-1:0] in_data_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [PIX_W-1:0] out_data_o
);
    import pal_lut_pkg::*;

    logic          run;
    logic          adv;
    logic          take;
    logic          idx_path;
    logic          wr_ok;
    logic          valid_q;
    logic [AW-1:0] idx;
    logic          idx_last;
    pal_sel_e      sel_d;
    pal_sel_e      out_sel;
    logic [PIX_W-1:0] pass_d;
    logic [CW-1:0] lane_q [NLANE];

    // Configuration check and flow control.
    always_comb begin
        cfg_err_o = en_i && !bypass_i && scaler_on_i;
        run       = en_i && !cfg_err_o;
        adv       = run && (!valid_q || out_ready_i);
        idx_path  = !bypass_i && (pal_mode_e'(mode_i) == MODE_IDX);
        take      = adv && in_valid_i;
        wr_ok     = tw_en_i && (!en_i || bypass_i);
        in_ready_o  = adv && (!idx_path || idx_last);
        out_valid_o = valid_q && run;
    end

    // Index unpacker for the indexed path.
    pal_index_unpack #(
        .WORD_W (WORD_W),
        .IDX_W  (AW)
    ) unpack_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run || !idx_path),
        .step  (take && idx_path),
        .depth (depth_i),
        .word  (in_data_i[WORD_W-1:0]),
        .idx   (idx),
        .last  (idx_last)
    );

    // One lane per color component; lane 0 is red, lane 2 is blue.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam int HI = (NLANE - l) * CW - 1;
        logic [AW-1:0] rd_addr;
        assign rd_addr = idx_path ? idx : in_data_i[HI -: AW];
        pal_lut_lane #(
            .DW (CW),
            .AW (AW)
        ) lane_i (
            .clk     (clk),
            .wr_en   (wr_ok),
            .wr_addr (tw_addr_i),
            .wr_data (tw_data_i[HI -: CW]),
            .rd_en   (take),
            .rd_addr (rd_addr),
            .rd_data (lane_q[l])
        );
    end

    // Path select and pass-through word (full word or alpha only).
    always_comb begin
        if (bypass_i) begin
            sel_d  = SEL_BYP;
            pass_d = in_data_i;
        end else if (idx_path) begin
            sel_d  = SEL_IDX;
            pass_d = {{CW{1'b1}}, {(PIX_W-CW){1'b0}}};
        end else begin
            sel_d  = SEL_GAM;
            pass_d = {in_data_i[PIX_W-1 -: CW], {(PIX_W-CW){1'b0}}};
        end
    end

    // Output register stage.
    pal_out_stage #(
        .CW (CW)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .adv      (adv),
        .in_valid (in_valid_i),
        .sel_d    (sel_d),
        .pass_d   (pass_d),
        .lane_r   (lane_q[0]),
        .lane_g   (lane_q[1]),
        .lane_b   (lane_q[2]),
        .valid_q  (valid_q),
        .sel_q    (out_sel),
        .data_o   (out_data_o)
    );
endmodule

// File: rtl/pal_lut_stage_chk.sv
// Protocol and configuration checker for pal_lut_stage, bound to the top.
// Assumes it observes the top ports and the output path select.
module pal_lut_stage_chk #(
    parameter int CW = 10,
    localparam int PIX_W = 4 * CW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             bypass_i,
    input logic             scaler_on_i,
    input logic             cfg_err_o,
    input logic             in_ready_o,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [PIX_W-1:0] out_data_o,
    input logic [1:0]       sel_q
);
    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!out_valid_o && !in_ready_o && !cfg_err_o));

    // R7
    scaler_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !bypass_i && scaler_on_i) |-> (cfg_err_o && !out_valid_o && !in_ready_o));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (en_i && !bypass_i && scaler_on_i));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (!out_valid_o || $stable(out_data_o)));

    // R3
    opaque_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && sel_q == 2'd1) |-> (out_data_o[PIX_W-1 -: CW] == {CW{1'b1}}));
endmodule

bind pal_lut_stage pal_lut_stage_chk #(.CW(CW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .bypass_i    (bypass_i),
    .scaler_on_i (scaler_on_i),
    .cfg_err_o   (cfg_err_o),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .sel_q       (out_sel)
);

// File: tb/pal_lut_stage_tb_top.sv
// Bench for pal_lut_stage: behavioural model with an expected-pixel queue,
// compared at every output transfer and every disabled clock.
module pal_lut_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        bypass = 1'b0;
    logic        mode = 1'b0;
    logic [1:0]  depth = 2'd0;
    logic        scaler = 1'b0;
    logic        cfg_err;
    logic        tw_en = 1'b0;
    logic [7:0]  tw_addr = '0;
    logic [29:0] tw_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [39:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [39:0] out_data;

    int checks = 0;
    int fails  = 0;
    logic [39:0] exp_q [$];
    string       tag_q [$];
    logic [9:0]  ref_r [256];
    logic [9:0]  ref_g [256];
    logic [9:0]  ref_b [256];
    bit          rdy_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;   // 125 MHz

    pal_lut_stage dut_i (
        .clk (clk), .rst_n (rst_n), .en_i (en), .bypass_i (bypass),
        .mode_i (mode), .depth_i (depth), .scaler_on_i (scaler),
        .cfg_err_o (cfg_err), .tw_en_i (tw_en), .tw_addr_i (tw_addr),
        .tw_data_i (tw_data), .in_valid_i (in_valid), .in_ready_o (in_ready),
        .in_data_i (in_data), .out_valid_o (out_valid), .out_ready_i (out_ready),
        .out_data_o (out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Downstream ready pattern.
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Monitor: every output transfer and every disabled cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!en) chk(!out_valid && !in_ready && !cfg_err, "R8 disabled", {37'd0, out_valid, in_ready, cfg_err}, 40'd0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected pixel", out_data, 40'd0);
                end else begin
                    automatic logic [39:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(out_data == e, t, out_data, e);
                end
            end
        end
    end

    function automatic logic [39:0] idx_pix(logic [7:0] i);
        return {10'h3FF, ref_r[i], ref_g[i], ref_b[i]};
    endfunction

    task automatic tbl_write(input logic [7:0] a, input logic [29:0] d, input bit accepted);
        @(posedge clk); #1;
        tw_en = 1'b1; tw_addr = a; tw_data = d;
        @(posedge clk); #1;
        tw_en = 1'b0;
        if (accepted) begin
            ref_r[a] = d[29:20]; ref_g[a] = d[19:10]; ref_b[a] = d[9:0];
        end
    endtask

    // Queue the expected pixels for a word, then offer it until consumed.
    task automatic send_word(input logic [39:0] w);
        if (bypass) begin
            exp_q.push_back(w); tag_q.push_back("R5 bypass");
        end else if (mode == 1'b1) begin
            exp_q.push_back({w[39:30], ref_r[w[29:22]], ref_g[w[19:12]], ref_b[w[9:2]]});
            tag_q.push_back("R4 gamma");
        end else begin
            for (int k = 0; k < (32 >> depth); k++) begin
                automatic int bits = 1 << depth;
                automatic logic [31:0] f = (w[31:0] >> (k * bits)) & ((32'd1 << bits) - 1);
                exp_q.push_back(idx_pix(f[7:0]));
                tag_q.push_back($sformatf("R2 R3 depth%0d field%0d", depth, k));
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = w;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !in_ready && !cfg_err, "R10 reset", {37'd0, out_valid, in_ready, cfg_err}, 40'd0);

        // R1: load the full table while disabled.
        for (int i = 0; i < 256; i++)
            tbl_write(8'(i), {10'(i * 3 + 7), 10'(1023 - 2 * i), 10'((i * 37) & 1023)}, 1'b1);

        // R10: enabled, idle.
        @(posedge clk); #1 en = 1'b1; mode = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!out_valid, "R10 idle after enable", {39'd0, out_valid}, 40'd0);
        end

        // R6: one-cycle latency with ready high.
        exp_q.push_back({10'h155, ref_r[8'h12], ref_g[8'h34], ref_b[8'h56]});
        tag_q.push_back("R6 R4 latency pixel");
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = {10'h155, 8'h12, 2'b01, 8'h34, 2'b10, 8'h56, 2'b11};
        @(negedge clk);
        chk(in_ready, "R6 accept", {39'd0, in_ready}, 40'd1);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid, "R6 valid next cycle", {39'd0, out_valid}, 40'd1);
        drain();

        // R4: gamma with stalls.
        rdy_rand = 1'b1;
        send_word({10'h2AB, 10'h3FF, 10'h000, 10'h1C4});
        send_word({10'h001, 10'h080, 10'h37D, 10'h2E9});
        send_word({10'h3FF, 10'h111, 10'h222, 10'h333});
        drain();

        // R2 R3: every index depth, with stalls.
        mode = 1'b0;
        for (int d = 0; d < 4; d++) begin
            depth = 2'(d);
            send_word({8'h0, 32'hA5C3_1E96});
            send_word({8'h0, 32'h0123_FEDC});
        end
        drain();
        rdy_rand = 1'b0;
        depth = 2'd3;
        send_word({8'h0, 32'h80FF_0107});
        drain();

        // R9: write while running is ignored; write in bypass is taken.
        mode = 1'b1;
        tbl_write(8'd200, 30'h3FFF_FFFF, 1'b0);
        send_word({10'h0AA, 8'd200, 2'b00, 8'd200, 2'b11, 8'd200, 2'b10});
        drain();
        @(posedge clk); #1 bypass = 1'b1;
        tbl_write(8'd201, {10'h3A1, 10'h0B2, 10'h1C3}, 1'b1);
        @(posedge clk); #1 bypass = 1'b0;
        send_word({10'h000, 8'd201, 2'b11, 8'd201, 2'b11, 8'd201, 2'b11});
        drain();

        // R5: bypass, with the scaler on as well (no error).
        bypass = 1'b1; scaler = 1'b1;
        rdy_rand = 1'b1;
        send_word(40'h12_3456_789A);
        send_word(40'hFE_DCBA_9876);
        drain();
        chk(!cfg_err, "R7 no error in bypass", {39'd0, cfg_err}, 40'd0);
        rdy_rand = 1'b0;

        // R7: lookup with scaler on, both modes.
        for (int m = 0; m < 2; m++) begin
            @(posedge clk); #1;
            bypass = 1'b0; mode = m[0]; in_valid = 1'b1; in_data = 40'h00_FFFF_FFFF;
            repeat (3) begin
                @(negedge clk);
                chk(cfg_err && !out_valid && !in_ready, "R7 scaler clash",
                    {37'd0, cfg_err, out_valid, in_ready}, 40'd4);
            end
            @(posedge clk); #1 in_valid = 1'b0;
        end
        @(posedge clk); #1 scaler = 1'b0;
        @(negedge clk);
        chk(!cfg_err, "R7 clears", {39'd0, cfg_err}, 40'd0);

        // R8: disabled with input offered.
        @(posedge clk); #1 en = 1'b0; in_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!in_ready && !out_valid, "R8 input offered", {38'd0, in_ready, out_valid}, 40'd0);
        end
        @(posedge clk); #1 in_valid = 1'b0;
        repeat (2) @(negedge clk);

        chk(exp_q.size() == 0, "R6 all pixels delivered", 40'(exp_q.size()), 40'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule